// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This block works out the first filter phase for one axis of a display scaler. It receives the source extent as a 16.16 fixed-point value and the destination extent in whole pixels. It also receives a chroma subsampling selector (factor 1 or factor 2) and a cosited flag. A restoring divider produces one quotient bit per clock and derives the scale ratio. The ratio covers the full span from the outer edge of the first pixel to the outer edge of the last pixel. The block then places the starting phase half a pixel before the first pixel centre, which is -0.5 or -0x8000 with a 16-bit fraction. It adds half a destination step, scaled down by the subsampling factor. For cosited chroma it adds a further offset. Finally it packs the result into a 16-bit register word with a sign-dependent trip bit.

A caller pulses `start` with the operands while the block is idle. It then waits for the single-cycle `done` pulse. The 16-bit word, the signed phase and the error flag stay steady from that pulse until the next result. For 4:2:0 content, a caller uses factor 1 without cositing for luma. For chroma it uses factor 2 with cositing on the horizontal axis, and factor 2 without cositing on the vertical axis.

Top module: `scl_init_phase`

## Requirements
- R1: While in reset and after reset, `done`, `busy` and `err` are 0 and `word` is 0x0000.
- R2: A `start` taken while idle with a non-zero destination drives `busy` high until the result. `busy` falls in the same cycle in which `done` pulses high for exactly one cycle. The results stay unchanged until the next `done`.
- R3: The scale is floor(src_size / dst_size) in 16.16. The phase is -0x8000 + floor(scale / (2*f)) plus the cosite offset, where f is 2 when `sub2`=1 and 1 otherwise. `phase` gives this value as a signed number with a 16-bit fraction.
- R4: When `cosited`=1 and `sub2`=1, the cosite offset is +0x4000. In every other combination it is 0.
- R5: A phase below -0x8000 or above 0x18000 sets `err` and forces `word` to 0. A phase of exactly 0x18000 is legal.
- R6: A negative phase is wrapped by adding 0x10000 and gives trip bit `word[0]`=0. A phase of zero or more is left as it is and gives `word[0]`=1.
- R7: `word[15:1]` equals bits 16:2 of the wrapped phase, that is (wrapped >> 2) & 0x7FFF.
- R8: A `start` with `dst_size`=0 skips the divider. In the next cycle `done` pulses with `err`=1, `word`=0 and `phase`=0.
- R9: `start` has no effect while `busy` is high. Exactly one result is produced per accepted start, and it is computed from the operands of that start.
- R10: A 4:1 downscale with f=1 gives phase 0x18000 and word 0xC001. A 1:4 upscale with f=1 gives phase -0x6000 and word 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calculation (taken while idle) |
| src_size | input | SRC_W (32) | Source extent, 16.16 fixed point |
| dst_size | input | DST_W (14) | Destination extent in pixels |
| sub2 | input | 1 | 1: subsampling factor 2, 0: factor 1 |
| cosited | input | 1 | Chroma sample cosited with the first luma sample |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Phase out of range or zero destination |
| phase | output | SRC_W+2 (34) | Signed initial phase, 16-bit fraction |
| word | output | 16 | Packed field in bits 15:1, trip bit in bit 0 |

## Verification
The checker takes four things for granted. `start` only matters when `busy` is low. The reset it watches is the synchronised internal one. Operands are sampled only on the cycle in which `start` is taken. And a zero-destination request is reported on the very next cycle, with no division. The driver waits for `busy` to drop before each request. It keeps operands within the port widths, and it issues extra `start` pulses during a division only in the test that checks they are ignored. Expected words come from plain integer arithmetic on the stated formula. The cases include both sides of the upper range limit, zero phase, cosited and non-cosited chroma, and fractional source extents.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
  localparam int FRAC_W  = 16;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = WORD_W - 1;
  // half a pixel in 16.16
  localparam int HALF_PIX    = 1 << (FRAC_W - 1);
  // cosite shift for factor 2: (2-1)*HALF_PIX/2
  localparam int COSITE_OFS  = HALF_PIX / 2;
  localparam int ONE_PIX     = 1 << FRAC_W;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/scl_div_restoring.sv
module scl_div_restoring #(
  parameter int N_W = 32,
  parameter int D_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic [N_W-1:0] quo,
  output logic           fin
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W:0]   rem_q, rem_d, rem_sh, rem_sub;
  logic [N_W-1:0] num_q, num_d, quo_q, quo_d;
  logic [D_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic act_q, act_d, fin_q, fin_d;
  logic ge, en;

  // one restoring step
  always_comb begin
    rem_sh  = {rem_q[D_W-1:0], num_q[N_W-1]};
    ge      = (rem_sh >= {1'b0, den_q});
    rem_sub = rem_sh - {1'b0, den_q};
  end

  always_comb begin
    rem_d = rem_q;
    num_d = num_q;
    quo_d = quo_q;
    den_d = den_q;
    cnt_d = cnt_q;
    act_d = act_q;
    fin_d = 1'b0;
    en    = go | act_q;
    if (go) begin
      rem_d = '0;
      num_d = num;
      quo_d = '0;
      den_d = den;
      cnt_d = CNT_W'(N_W);
      act_d = 1'b1;
    end else if (act_q) begin
      rem_d = ge ? rem_sub : rem_sh;
      num_d = num_q << 1;
      quo_d = {quo_q[N_W-2:0], ge};
      cnt_d = cnt_q - CNT_W'(1);
      act_d = (cnt_q != CNT_W'(1));
      fin_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fin_q <= fin_d;
      if (en) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      num_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      num_q <= num_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign quo = quo_q;
  assign fin = fin_q;
endmodule

// File: rtl/scl_phase_core.sv
module scl_phase_core
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int PH_W    = SCALE_W + 2
) (
  input  logic [SCALE_W-1:0]     scale,
  input  logic                   sub2,
  input  logic                   cosited,
  output logic signed [PH_W-1:0] phase,
  output logic                   err,
  output logic [WORD_W-1:0]      word
);
  localparam logic signed [PH_W-1:0] PH_MIN  = PH_W'(-HALF_PIX);
  localparam logic signed [PH_W-1:0] PH_MAX  = PH_W'(3 * HALF_PIX);
  localparam logic signed [PH_W-1:0] PH_BASE = PH_W'(HALF_PIX);
  localparam logic signed [PH_W-1:0] PH_COS  = PH_W'(COSITE_OFS);
  localparam logic [PH_W-1:0]        WRAP    = PH_W'(ONE_PIX);

  logic signed [PH_W-1:0] half_step, cos_add;
  logic [PH_W-1:0]        wrapped;
  logic                   trip;

  always_comb begin
    half_step = $signed({2'b00, (sub2 ? (scale >> 2) : (scale >> 1))});
    cos_add   = (sub2 && cosited) ? PH_COS : '0;
    phase     = half_step + cos_add - PH_BASE;
    err       = (phase < PH_MIN) || (phase > PH_MAX);
    trip      = ~phase[PH_W-1];
    wrapped   = phase[PH_W-1] ? (phase + WRAP) : phase;
    word      = err ? '0 : {wrapped[FIELD_W+1:2], trip};
  end
endmodule

// File: rtl/scl_init_phase.sv
module scl_init_phase
  import scl_phase_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int DST_W = 14,
  localparam int PH_W = SRC_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SRC_W-1:0]       src_size,
  input  logic [DST_W-1:0]       dst_size,
  input  logic                   sub2,
  input  logic                   cosited,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic signed [PH_W-1:0] phase,
  output logic [WORD_W-1:0]      word
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ctl_state_e state_q, state_d;
  logic sub2_q, sub2_d, cos_q, cos_d;
  logic done_q, done_d, err_q, err_d;
  logic signed [PH_W-1:0] phase_q, phase_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic accept, dst_zero, div_go, div_fin, res_en, opt_en;
  logic [SRC_W-1:0] scale;
  logic signed [PH_W-1:0] core_phase;
  logic core_err;
  logic [WORD_W-1:0] core_word;

  assign dst_zero = (dst_size == '0);
  assign accept   = start && (state_q == ST_IDLE);
  assign div_go   = accept && !dst_zero;

  scl_div_restoring #(.N_W(SRC_W), .D_W(DST_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .go    (div_go),
    .num   (src_size),
    .den   (dst_size),
    .quo   (scale),
    .fin   (div_fin)
  );

  scl_phase_core #(.SCALE_W(SRC_W), .PH_W(PH_W)) u_core (
    .scale   (scale),
    .sub2    (sub2_q),
    .cosited (cos_q),
    .phase   (core_phase),
    .err     (core_err),
    .word    (core_word)
  );

  always_comb begin
    state_d = state_q;
    sub2_d  = sub2_q;
    cos_d   = cos_q;
    opt_en  = div_go;
    done_d  = 1'b0;
    err_d   = err_q;
    phase_d = phase_q;
    word_d  = word_q;
    res_en  = 1'b0;
    if (div_go) begin
      state_d = ST_RUN;
      sub2_d  = sub2;
      cos_d   = cosited;
    end
    if (accept && dst_zero) begin
      res_en  = 1'b1;
      done_d  = 1'b1;
      err_d   = 1'b1;
      phase_d = '0;
      word_d  = '0;
    end else if (div_fin && state_q == ST_RUN) begin
      state_d = ST_IDLE;
      res_en  = 1'b1;
      done_d  = 1'b1;
      err_d   = core_err;
      phase_d = core_phase;
      word_d  = core_word;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sub2_q <= 1'b0;
      cos_q  <= 1'b0;
    end else if (opt_en) begin
      sub2_q <= sub2_d;
      cos_q  <= cos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q   <= 1'b0;
      phase_q <= '0;
      word_q  <= '0;
    end else if (res_en) begin
      err_q   <= err_d;
      phase_q <= phase_d;
      word_q  <= word_d;
    end
  end

  assign busy  = (state_q == ST_RUN);
  assign done  = done_q;
  assign err   = err_q;
  assign phase = phase_q;
  assign word  = word_q;
endmodule

// File: rtl/scl_init_phase_chk.sv
module scl_init_phase_chk #(
  parameter int PH_W  = 34,
  parameter int DST_W = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [DST_W-1:0]       dst_size,
  input logic                   busy,
  input logic                   done,
  input logic                   err,
  input logic signed [PH_W-1:0] phase,
  input logic [15:0]            word
);
  localparam logic signed [PH_W-1:0] LO = PH_W'(-32768);
  localparam logic signed [PH_W-1:0] HI = PH_W'(98304);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(start && !busy && dst_size == '0)));

  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (phase >= LO && phase <= HI));

  assert_err_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (word == 16'h0000));

  assert_trip_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word[0] == !phase[PH_W-1]));

  assert_zero_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dst_size == '0) |=> (done && err && word == 16'h0000));
endmodule

bind scl_init_phase scl_init_phase_chk #(.PH_W(PH_W), .DST_W(DST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .dst_size (dst_size),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .phase    (phase),
  .word     (word)
);

// File: tb/sim_scl_init_phase.sv
`timescale 1ns/1ps
module sim_scl_init_phase;
  localparam int SRC_W = 32;
  localparam int DST_W = 14;
  localparam int PH_W  = SRC_W + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [SRC_W-1:0] src_size;
  logic [DST_W-1:0] dst_size;
  logic sub2, cosited;
  logic busy, done, err;
  logic signed [PH_W-1:0] phase;
  logic [15:0] word;

  always #4 clk = ~clk;

  scl_init_phase #(.SRC_W(SRC_W), .DST_W(DST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_size(src_size),
    .dst_size(dst_size), .sub2(sub2), .cosited(cosited), .busy(busy),
    .done(done), .err(err), .phase(phase), .word(word)
  );

  typedef struct {
    logic [15:0]     word;
    logic            err;
    logic [PH_W-1:0] ph;
    string           tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  int pushed = 0;
  int seen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input longint s, input longint d, input bit f2,
                                 input bit cs, input string tag);
    exp_t e;
    longint sc, ph, p;
    e.tag = tag;
    if (d == 0) begin
      e.err = 1'b1; e.word = 16'h0; e.ph = '0;
      return e;
    end
    sc = s / d;
    ph = (f2 ? (sc >> 2) : (sc >> 1)) + ((f2 && cs) ? 16384 : 0) - 32768;
    e.ph  = ph[PH_W-1:0];
    e.err = (ph < -32768) || (ph > 98304);
    if (e.err) e.word = 16'h0;
    else begin
      p = (ph < 0) ? ph + 65536 : ph;
      e.word = {p[16:2], (ph >= 0) ? 1'b1 : 1'b0};
    end
    return e;
  endfunction

  task automatic drive(input longint s, input longint d, input bit f2, input bit cs,
                       input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    src_size = s[SRC_W-1:0];
    dst_size = d[DST_W-1:0];
    sub2 = f2; cosited = cs; start = 1'b1;
    sb.push_back(model(s, d, f2, cs, tag));
    pushed++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      seen++;
      if (sb.size() == 0) check(1'b0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(word == e.word, {e.tag, " word"}, longint'(word), longint'(e.word));
        check(err == e.err, {e.tag, " err"}, longint'(err), longint'(e.err));
        check(phase == e.ph, {e.tag, " phase"}, longint'(phase), longint'(e.ph));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; src_size = '0; dst_size = '0; sub2 = 0; cosited = 0;
    repeat (3) @(negedge clk);
    check(!done && !busy && !err && word == 0, "R1 in reset", longint'(word), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !busy && !err && word == 0, "R1 after reset", longint'(word), 0);

    drive(64'd16 << 16, 4, 0, 0, "R10 down 4:1 R5 edge");
    drive(64'd4 << 16, 16, 0, 0, "R10 up 1:4 R6 neg");
    drive(64'd1920 << 16, 1920, 0, 0, "R6 zero phase");
    drive(64'd1920 << 16, 960, 1, 1, "R4 cosited f2 R7");
    drive(64'd1920 << 16, 960, 1, 0, "R4 plain f2");
    drive(64'd16 << 16, 4, 0, 1, "R4 cosited f1");
    drive(64'h40002, 1, 0, 0, "R5 above max");
    drive(64'd300 << 16, 0, 0, 0, "R8 zero dst");
    drive(64'h000A8000, 7, 1, 1, "R3 fractional src");
    drive(64'd16383 << 16, 16383, 1, 1, "R3 wide dst");
    drive(64'd100 << 16, 1000, 1, 1, "R3 f2 upscale");
    drive(64'd100 << 16, 0, 1, 1, "R8 zero dst again");
    drive(64'd7 << 16, 3, 0, 0, "R3 after zero dst");
    for (int i = 1; i <= 16; i++) begin
      drive((longint'(i) * 37 + 5) << 14, i * 91 % 2000 + 1, i[0], i[1], "R3 sweep");
    end

    // R9: extra starts while busy are ignored
    drive(64'd8 << 16, 2, 0, 0, "R9 first");
    src_size = 32'd1 << 16; dst_size = 14'd64; sub2 = 1; cosited = 1; start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy during division", longint'(busy), 1);
    src_size = '0; dst_size = '0;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (60) @(negedge clk);
    check(sb.size() == 0, "R9 queue drained", sb.size(), 0);
    check(seen == pushed, "R9 one result per accepted start", seen, pushed);
    check(!done, "R2 done is a pulse", longint'(done), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule